// File: doc/BRIEF.md
# Smartcard Asynchronous Character Transceiver

This block moves single characters to and from an asynchronous smartcard over one shared open-drain data line. It also makes the card clock by dividing the system clock with a small programmable value. The host writes bytes through a valid/ready transmit port and takes received bytes from a valid/ready receive port. Two one-cycle pulses report problems: one for a received character with bad parity, and one for a transmit that ran out of retries.

Each character on the line has this form:
- a low start bit;
- eight data bits, least significant first;
- an even parity bit;
- a guard period, either half a bit or one and a half bits long.

In the long-guard setting the two ends use the guard period to flag parity errors. The receiver holds the line low to signal a bad character. The transmitter checks the line during the guard period and sends the same byte again when it sees that signal. Bit time is given in card-clock cycles, and the block times every event in half-bit steps counted from the start edge.

Top module: `sc_uart`

## Requirements
- R1: With `presc_i` = N > 0, `sclk_o` stays high for N system cycles and then low for N cycles. With N = 0, `sclk_o` is held low.
- R2: One bit lasts `etu_i` rising edges of `sclk_o`, where `etu_i` is even and at least 2. Every character time is counted from the start edge in half-bit steps.
- R3: `io_drv_o` = 1 pulls the line low and 0 releases it. A transmitted character is a start bit (low) for one bit, then `tx_data_i` bits 0 to 7, then a parity bit that makes the number of ones in data plus parity even. Driving begins in the cycle after a transmit handshake.
- R4: `tx_ready_o` comes back after 11.5 bits when `stop_long_i` = 1, and after 10.5 bits when `stop_long_i` = 0, counted from the handshake. This holds when no retry takes place.
- R5: The receiver samples at mid-bit. A start bit that is high at its middle is ignored. A character with good parity raises `rx_valid_o` with the byte. `rx_valid_o` and `rx_data_o` hold until `rx_ready_i`. A good character that completes while an earlier one is still unaccepted is discarded.
- R6: A received parity error gives a one-cycle `rx_perr_o` and delivers no byte. With `stop_long_i` = 1 the receiver also pulls the line low from 10.5 to 11.5 bits after the start edge.
- R7: With `stop_long_i` = 0, a received parity error is never signalled on the line.
- R8: With `stop_long_i` = 1 the transmitter samples the line 11 bits after the start. A low sample means the card rejected the character. The same byte is then sent again starting 12.5 bits after the previous start, up to `retries_i` times. After that the block pulses `tx_fail_o` for one cycle and goes idle.
- R9: When idle (`tx_ready_o` = 1) the block never drives the line. Reset leaves the line released, `sclk_o` low, `tx_ready_o` high and `rx_valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presc_i | input | PRESC_W | Card clock half-period in system cycles; 0 stops the clock |
| etu_i | input | ETU_W | Bit time in card-clock cycles (even) |
| stop_long_i | input | 1 | 1: 1.5-bit guard with error signalling; 0: 0.5-bit guard |
| retries_i | input | RTR_W | Maximum number of resends after rejection |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_data_i | input | 8 | Byte to transmit |
| tx_ready_o | output | 1 | Block idle, accepts a transmit byte |
| rx_valid_o | output | 1 | Received byte available |
| rx_data_o | output | 8 | Received byte |
| rx_ready_i | input | 1 | Host takes the received byte |
| rx_perr_o | output | 1 | One-cycle pulse on received parity error |
| tx_fail_o | output | 1 | One-cycle pulse when retries are exhausted |
| sclk_o | output | 1 | Card clock |
| io_i | input | 1 | Level of the shared data line |
| io_drv_o | output | 1 | 1 pulls the data line low |

## Verification
The assertions check on every cycle that:
- the card clock stops when the divider is zero and toggles each cycle when it is one;
- the line stays free whenever the block is idle;
- a transmit handshake starts a start bit at once;
- a held receive byte stays stable;
- a parity error never coincides with delivery;
- the failure flag is a single pulse.

The bench's scenarios are the only way to show the rest:
- the bit order and parity on the line;
- the two guard lengths;
- where the error pulse sits in time, and that it is absent in the short-guard mode;
- resending after a rejected character and giving up after the retry limit.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_RX} sc_state_e;
  localparam int unsigned HB_W      = 5;
  localparam int unsigned HB_PARITY = 18;  // half-bit index of parity sample
  localparam int unsigned HB_DATA   = 20;  // end of parity bit
  localparam int unsigned HB_ERR_LO = 21;  // error window start
  localparam int unsigned HB_ERR_HI = 23;  // error window end (exclusive)
  localparam int unsigned HB_SHORT  = 21;
  localparam int unsigned HB_LONG   = 23;
  localparam int unsigned HB_RESEND = 25;
endpackage

// File: rtl/sc_clkgen.sv
module sc_clkgen #(
  parameter int unsigned PRESC_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               sclk_o,
  output logic               tick_o
);
  logic [PRESC_W-1:0] cnt_q;
  logic               wrap;

  assign wrap   = (presc_i != '0) && (cnt_q >= presc_i - PRESC_W'(1));
  assign tick_o = wrap && !sclk_o;  // rising edge of card clock

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (presc_i == '0) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      sclk_o <= ~sclk_o;
    end else begin
      cnt_q <= cnt_q + PRESC_W'(1);
    end
  end
endmodule

// File: rtl/sc_hbtimer.sv
module sc_hbtimer #(
  parameter int unsigned ETU_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ETU_W-1:0] etu_i,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic             hb_o
);
  logic [ETU_W-1:0] half;
  logic [ETU_W-1:0] cnt_q;
  logic             full;

  assign half = etu_i >> 1;
  assign full = (cnt_q >= half - ETU_W'(1));
  assign hb_o = tick_i && !clr_i && full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= full ? '0 : cnt_q + ETU_W'(1);
  end
endmodule

// File: rtl/sc_uart.sv
module sc_uart
  import sc_pkg::*;
#(
  parameter int unsigned PRESC_W = 5,
  parameter int unsigned ETU_W   = 12,
  parameter int unsigned RTR_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [ETU_W-1:0]   etu_i,
  input  logic               stop_long_i,
  input  logic [RTR_W-1:0]   retries_i,
  input  logic               tx_valid_i,
  input  logic [7:0]         tx_data_i,
  output logic               tx_ready_o,
  output logic               rx_valid_o,
  output logic [7:0]         rx_data_o,
  input  logic               rx_ready_i,
  output logic               rx_perr_o,
  output logic               tx_fail_o,
  output logic               sclk_o,
  input  logic               io_i,
  output logic               io_drv_o
);
  sc_state_e        st_q;
  logic [HB_W-1:0]  hbn_q;
  logic [7:0]       txbuf_q, shr_q;
  logic             errd_q;
  logic [RTR_W-1:0] rcnt_q;
  logic             io_s1, io_s2, io_s3;
  logic             tick, hb, accept, rx_start, txbit;
  logic [HB_W-1:0]  tx_end, rx_end;
  logic [3:0]       bidx;

  sc_clkgen #(.PRESC_W(PRESC_W)) u_clkgen (
    .clk_i, .rst_ni, .presc_i, .sclk_o, .tick_o(tick)
  );

  sc_hbtimer #(.ETU_W(ETU_W)) u_hbtimer (
    .clk_i, .rst_ni, .etu_i, .tick_i(tick), .clr_i(accept || rx_start), .hb_o(hb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) {io_s1, io_s2, io_s3} <= 3'b111;
    else         {io_s1, io_s2, io_s3} <= {io_i, io_s1, io_s2};
  end

  assign tx_ready_o = (st_q == ST_IDLE);
  assign accept     = tx_ready_o && tx_valid_i;
  assign rx_start   = tx_ready_o && !tx_valid_i && io_s3 && !io_s2;
  assign bidx       = hbn_q[4:1];
  assign rx_end     = stop_long_i ? HB_W'(HB_LONG) : HB_W'(HB_SHORT);
  assign tx_end     = errd_q ? HB_W'(HB_RESEND) : rx_end;

  always_comb begin
    if (bidx == 4'd0)      txbit = 1'b0;
    else if (bidx <= 4'd8) txbit = txbuf_q[3'(bidx - 4'd1)];
    else if (bidx == 4'd9) txbit = ^txbuf_q;
    else                   txbit = 1'b1;
  end

  assign io_drv_o = ((st_q == ST_TX) && (hbn_q < HB_W'(HB_DATA)) && !txbit) ||
                    ((st_q == ST_RX) && errd_q && stop_long_i &&
                     (hbn_q >= HB_W'(HB_ERR_LO)) && (hbn_q < HB_W'(HB_ERR_HI)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      hbn_q      <= '0;
      txbuf_q    <= '0;
      shr_q      <= '0;
      errd_q     <= 1'b0;
      rcnt_q     <= '0;
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
      rx_perr_o  <= 1'b0;
      tx_fail_o  <= 1'b0;
    end else begin
      rx_perr_o <= 1'b0;
      tx_fail_o <= 1'b0;
      if (rx_ready_i) rx_valid_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          hbn_q  <= '0;
          errd_q <= 1'b0;
          if (accept) begin
            st_q    <= ST_TX;
            txbuf_q <= tx_data_i;
            rcnt_q  <= '0;
          end else if (rx_start) begin
            st_q <= ST_RX;
          end
        end
        ST_TX: if (hb) begin
          hbn_q <= hbn_q + HB_W'(1);
          if (hbn_q == HB_W'(HB_ERR_LO) && stop_long_i && !io_s2) errd_q <= 1'b1;
          if (hbn_q + HB_W'(1) == tx_end) begin
            if (!errd_q) begin
              st_q <= ST_IDLE;
            end else if (rcnt_q < retries_i) begin
              rcnt_q <= rcnt_q + RTR_W'(1);
              hbn_q  <= '0;
              errd_q <= 1'b0;
            end else begin
              tx_fail_o <= 1'b1;
              st_q      <= ST_IDLE;
            end
          end
        end
        ST_RX: if (hb) begin
          hbn_q <= hbn_q + HB_W'(1);
          if (hbn_q == '0 && io_s2) begin
            st_q <= ST_IDLE;  // glitch, not a start bit
          end else if (!hbn_q[0] && hbn_q >= HB_W'(2) && hbn_q < HB_W'(HB_PARITY)) begin
            shr_q <= {io_s2, shr_q[7:1]};
          end else if (hbn_q == HB_W'(HB_PARITY)) begin
            errd_q <= (^shr_q) ^ io_s2;
          end
          if (hbn_q + HB_W'(1) == rx_end) begin
            st_q <= ST_IDLE;
            if (errd_q) rx_perr_o <= 1'b1;
            else if (!rx_valid_o) begin
              rx_valid_o <= 1'b1;
              rx_data_o  <= shr_q;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_uart_chk.sv
module sc_uart_chk #(
  parameter int unsigned PRESC_W = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [PRESC_W-1:0] presc_i,
  input logic               sclk_o,
  input logic               tx_valid_i,
  input logic               tx_ready_o,
  input logic               io_drv_o,
  input logic               rx_valid_o,
  input logic               rx_ready_i,
  input logic [7:0]         rx_data_o,
  input logic               rx_perr_o,
  input logic               tx_fail_o
);
  AST_SCLK_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (presc_i == '0) |=> !sclk_o);  // R1
  AST_SCLK_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (presc_i == PRESC_W'(1) && $past(presc_i) == PRESC_W'(1)) |-> (sclk_o != $past(sclk_o)));  // R1
  AST_TX_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> (io_drv_o && !tx_ready_o));  // R3
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> !io_drv_o);  // R9
  AST_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));  // R5
  AST_PERR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_valid_o) |-> !rx_perr_o);  // R6
  AST_FAIL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_fail_o |=> !tx_fail_o);  // R8
endmodule

bind sc_uart sc_uart_chk #(.PRESC_W(PRESC_W)) u_chk (.*);

// File: tb/sc_uart_test.sv
`timescale 1ns/1ps
module sc_uart_test;
  localparam int E = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] presc = 5'd2;
  logic [11:0] etu = 12'(E);
  logic       stop_long = 1'b1;
  logic [2:0] retries = 3'd2;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_ready, rx_valid, rx_perr, tx_fail, sclk, drv;
  logic [7:0] rx_data;
  logic       rx_ready = 1'b1;
  logic       card_drv = 1'b0;
  wire        line = ~(drv | card_drv);

  int checks = 0, errors = 0;
  int perr_cnt = 0, fail_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sc_uart uut (
    .clk_i(clk), .rst_ni(rst_n), .presc_i(presc), .etu_i(etu),
    .stop_long_i(stop_long), .retries_i(retries),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .rx_ready_i(rx_ready),
    .rx_perr_o(rx_perr), .tx_fail_o(tx_fail), .sclk_o(sclk),
    .io_i(line), .io_drv_o(drv)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rx_perr) perr_cnt++;
    if (rst_n && tx_fail) fail_cnt++;
  end

  // reference model of the card clock, compared each cycle
  bit mon_on = 0;
  int epoch = 0, seen = -1, run = 0;
  bit run_ok = 0, prev = 0;
  always @(negedge clk) begin
    if (!rst_n || !mon_on || epoch != seen) begin
      seen = epoch; run_ok = 0; run = 0; prev = sclk;
    end else if (sclk == prev) run++;
    else begin
      if (run_ok) chk(run == int'(presc), "R1 sclk half period", run, int'(presc));
      run_ok = 1; run = 1; prev = sclk;
    end
  end

  task automatic cwait(input int n);
    repeat (n) @(posedge sclk);
    @(negedge clk);
  endtask

  task automatic card_rx(output logic [7:0] d, output logic p, input bit nack);
    @(negedge clk);
    while (line) @(negedge clk);
    cwait(E/2);
    for (int i = 0; i < 8; i++) begin cwait(E); d[i] = line; end
    cwait(E); p = line;
    if (nack) begin
      cwait(E); card_drv = 1'b1;
      cwait(E); card_drv = 1'b0;
    end
  endtask

  task automatic card_tx(input logic [7:0] d, input bit badpar, output bit saw_err);
    card_drv = 1'b1; cwait(E);
    for (int i = 0; i < 8; i++) begin card_drv = ~d[i]; cwait(E); end
    card_drv = ~((^d) ^ badpar); cwait(E);
    card_drv = 1'b0; cwait(E);
    saw_err = !line;
    cwait(2*E);
  endtask

  task automatic host_send(input logic [7:0] d, output int dur);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = d;
    @(negedge clk);
    tx_valid = 1'b0;
    dur = 0;
    while (!tx_ready) begin @(negedge clk); dur++; end
  endtask

  initial begin
    #(4*150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, d2; logic p, p2; bit se; int dur, f0, pe0;
    logic [7:0] pats [4] = '{8'hA5, 8'h00, 8'hFF, 8'h3C};
    repeat (3) @(negedge clk);
    chk(!drv && !sclk, "R9 reset line and clock", drv, 0);
    chk(tx_ready && !rx_valid, "R9 reset handshake", tx_ready, 1);
    rst_n = 1'b1;
    mon_on = 1;

    // R3 framing, R4 long guard
    foreach (pats[k]) begin
      fork
        host_send(pats[k], dur);
        card_rx(d, p, 1'b0);
      join
      chk(d == pats[k], "R3 data bits", d, pats[k]);
      chk(((^d) ^ p) == 1'b0, "R3 even parity", p, ^pats[k]);
      chk(dur >= 728 && dur <= 748, "R4 long guard duration", dur, 736);
      repeat (50) @(negedge clk);
    end

    // R4 short guard
    stop_long = 1'b0;
    fork host_send(8'h96, dur); card_rx(d, p, 1'b0); join
    chk(d == 8'h96, "R3 data short guard", d, 8'h96);
    chk(dur >= 664 && dur <= 684, "R4 short guard duration", dur, 672);
    stop_long = 1'b1;
    repeat (50) @(negedge clk);

    // R5 reception and hold
    rx_ready = 1'b0;
    card_tx(8'h5A, 1'b0, se);
    chk(rx_valid && rx_data == 8'h5A, "R5 received byte", rx_data, 8'h5A);
    chk(!se, "R6 no error signal on good parity", se, 0);
    repeat (20) @(negedge clk);
    chk(rx_valid && rx_data == 8'h5A, "R5 byte held", rx_valid, 1);
    repeat (50) @(negedge clk);
    card_tx(8'hC3, 1'b0, se);
    chk(rx_valid && rx_data == 8'h5A, "R5 later byte discarded", rx_data, 8'h5A);
    rx_ready = 1'b1;
    @(negedge clk);
    chk(!rx_valid, "R5 released by ready", rx_valid, 0);
    repeat (50) @(negedge clk);

    // R6 parity error with signalling
    pe0 = perr_cnt;
    card_tx(8'h71, 1'b1, se);
    chk(se, "R6 error signal on line", se, 1);
    chk(perr_cnt == pe0 + 1, "R6 parity flag", perr_cnt - pe0, 1);
    chk(!rx_valid, "R6 no delivery", rx_valid, 0);
    repeat (50) @(negedge clk);

    // R7 short guard, no signalling
    stop_long = 1'b0;
    pe0 = perr_cnt;
    card_tx(8'h71, 1'b1, se);
    chk(!se, "R7 no error signal", se, 0);
    chk(perr_cnt == pe0 + 1, "R7 parity flag", perr_cnt - pe0, 1);
    chk(!rx_valid, "R7 no delivery", rx_valid, 0);
    stop_long = 1'b1;
    repeat (50) @(negedge clk);

    // R8 one rejection then success
    f0 = fail_cnt;
    fork
      host_send(8'h81, dur);
      begin card_rx(d, p, 1'b1); card_rx(d2, p2, 1'b0); end
    join
    chk(d == 8'h81 && d2 == 8'h81, "R8 resent byte", d2, 8'h81);
    chk(fail_cnt == f0, "R8 no failure after accept", fail_cnt - f0, 0);
    repeat (50) @(negedge clk);

    // R8 retries exhausted
    retries = 3'd1;
    f0 = fail_cnt;
    fork
      host_send(8'h42, dur);
      begin card_rx(d, p, 1'b1); card_rx(d2, p2, 1'b1); end
    join
    repeat (10) @(negedge clk);
    chk(fail_cnt == f0 + 1, "R8 failure pulse", fail_cnt - f0, 1);
    chk(d2 == 8'h42, "R8 retry content", d2, 8'h42);
    se = 0;
    repeat (1000) begin @(negedge clk); if (drv) se = 1; end
    chk(!se, "R9 no third send", se, 0);

    // R1 other divider values, R2 bit time with new divider
    mon_on = 0; presc = 5'd3; epoch++; mon_on = 1;
    fork host_send(8'h1E, dur); card_rx(d, p, 1'b0); join
    chk(d == 8'h1E, "R2 bit time follows divider", d, 8'h1E);
    mon_on = 0; presc = 5'd0;
    repeat (3) @(negedge clk);
    se = 0;
    repeat (50) begin @(negedge clk); if (sclk) se = 1; end
    chk(!se, "R1 clock stopped", se, 0);
    presc = 5'd2; epoch++; mon_on = 1;
    repeat (200) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule